// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter with Preset

This block is a 4-bit counter with separate strobes for counting up and counting down. It sits on one system clock. Both strobes are re-timed through a short synchronizer chain and then checked for rising edges. A rising edge on the up strobe adds one to the count, but only while the down strobe is high. A rising edge on the down strobe subtracts one, but only while the up strobe is high. A parameter picks the modulus: decade (0 to 9) or binary (0 to 15).

A synchronous master clear and an active-low parallel load set the count directly, with no strobe needed. The active-low carry and borrow outputs mark the terminal count. Each one is low only while its own strobe is low, so it forms a pulse half a strobe period wide. The trailing rising edge of that pulse is the count edge for the next stage. To chain stages, wire a lower stage's carry to the next stage's up strobe and its borrow to the next stage's down strobe.

On every system clock the core picks one of five named actions. These are `ACT_CLEAR`, `ACT_LOAD`, `ACT_UP`, `ACT_DOWN` and `ACT_HOLD`, chosen in that order of priority. Several strobe patterns lead to `ACT_HOLD`:
- no edge;
- an edge whose opposite strobe is low;
- edges on both strobes in the same cycle.

Top module: `dual_strobe_counter`

## Requirements
- R1: A rising up-strobe edge raises the count by one, but only if the down strobe is high. While the down strobe is low, the count holds.
- R2: A rising down-strobe edge lowers the count by one, but only if the up strobe is high. While the up strobe is low, the count holds.
- R3: While `load_n` is 0 (and `clear` is 0), `count` takes `preset` at the next clock. Any strobe edge seen in that cycle is dropped.
- R4: While `clear` is 1, `count` becomes 0 at the next clock, whatever `load_n` and the strobes do. After reset, `count` is 0 and `carry_n` and `borrow_n` are 1.
- R5: The top value is 9 when DECADE=1 and 15 when DECADE=0. An up step from the top value gives 0, and a down step from 0 gives the top value.
- R6: `carry_n` is 0 exactly when the count equals the top value and the synchronized up strobe is low. It returns to 1 once the up strobe's rising edge is synchronized.
- R7: `borrow_n` is 0 exactly when the count is 0 and the synchronized down strobe is low. It returns to 1 once the down strobe's rising edge is synchronized.
- R8: If rising edges of both strobes are detected in the same clock, the count holds.
- R9: In decade mode, counts 10 to 15 become legal after one step. Up steps: 11, 13 and 15 go to 0; 10 goes to 1, 12 to 3, and 14 to 5. Down steps: 10..15 go to 4..9, which is the value minus 6.
- R10: Connect a stage's `carry_n` to the next stage's `stb_up` and its `borrow_n` to the next stage's `stb_dn`. The upper stage then steps up once each time the lower stage wraps up from 9 to 0. It steps down once each time the lower stage wraps down from 0 to 9.
- R11: A strobe change shows in `count` at the third rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_up | input | 1 | Up-count strobe; a rising edge counts |
| stb_dn | input | 1 | Down-count strobe; a rising edge counts |
| load_n | input | 1 | Active-low parallel load |
| clear | input | 1 | Master clear, highest priority |
| preset | input | 4 | Value loaded while `load_n` is low |
| count | output | 4 | Current count |
| carry_n | output | 1 | Active-low terminal count while counting up |
| borrow_n | output | 1 | Active-low terminal count while counting down |

## Verification
Three situations are hard to reach from the ports:
- Both strobes rising in the same clock: the bench lowers both strobes, then releases them at the same instant.
- A gated edge: it holds one strobe low while it pulses the other. When that strobe is released, the edge it produces becomes a real count in the opposite direction, and the bench expects that step too.
- A cascade borrow and carry at an illegal decade value: presets of 10 to 15 reach those counts. A second stage, driven only by the first stage's carry and borrow, then shows whether each wrap produced exactly one edge.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    localparam int CNT_W = 4;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_LOAD,
        ACT_UP,
        ACT_DOWN
    } cnt_act_e;

    // Up step; decade mode folds 10..15 back into the legal range
    function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] v,
                                                 input logic dec);
        logic [CNT_W-1:0] r;
        if (!dec) begin
            r = v + 1'b1;
        end else if (v < 4'd9) begin
            r = v + 1'b1;
        end else if (v == 4'd9) begin
            r = '0;
        end else if (v[0]) begin
            r = '0;
        end else begin
            r = v - 4'd9;
        end
        return r;
    endfunction

    // Down step; decade mode maps 10..15 onto 4..9
    function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v,
                                                   input logic dec);
        logic [CNT_W-1:0] r;
        if (!dec) begin
            r = v - 1'b1;
        end else if (v == '0) begin
            r = 4'd9;
        end else if (v > 4'd9) begin
            r = v - 4'd6;
        end else begin
            r = v - 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/dsc_strobe_sync.sv
module dsc_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic level,
    output logic rise
);

    localparam int LAST = STAGES - 1;

    // chain[LAST] is the synchronized level, chain[STAGES] its one-clock-old copy
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;          // idle-high strobes: no edge out of reset
        end else begin
            chain <= {chain[STAGES-1:0], strobe};
        end
    end

    always_comb begin
        level = chain[LAST];
        rise  = chain[LAST] & ~chain[STAGES];
    end

    // R11: a detected edge lasts exactly one clock
    a_r11_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/dsc_count_core.sv
module dsc_count_core
    import dsc_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load_n,
    input  logic [CNT_W-1:0] preset,
    input  logic             up_lvl,
    input  logic             up_rise,
    input  logic             dn_lvl,
    input  logic             dn_rise,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] TOP = DECADE ? 4'd9 : 4'd15;

    cnt_act_e         act;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;

    // Action selection, highest priority first
    always_comb begin
        if (clear) begin
            act = ACT_CLEAR;
        end else if (!load_n) begin
            act = ACT_LOAD;
        end else if (up_rise && dn_rise) begin
            act = ACT_HOLD;
        end else if (up_rise && dn_lvl) begin
            act = ACT_UP;
        end else if (dn_rise && up_lvl) begin
            act = ACT_DOWN;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_comb begin
        unique case (act)
            ACT_CLEAR: count_d = '0;
            ACT_LOAD:  count_d = preset;
            ACT_UP:    count_d = step_up(count_q, DECADE);
            ACT_DOWN:  count_d = step_down(count_q, DECADE);
            default:   count_d = count_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count_q == '0));

    a_r3_load_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load_n) |=> (count_q == $past(preset)));

    a_r8_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && up_rise && dn_rise) |=> $stable(count_q));

    a_r1_gated_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && up_rise && !dn_lvl && !dn_rise) |=> $stable(count_q));

    a_r2_gated_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && dn_rise && !up_lvl && !up_rise) |=> $stable(count_q));

    a_r9_up_lands_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && up_rise && dn_lvl && !dn_rise) |=> (count_q <= TOP));

    a_r9_down_lands_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && dn_rise && up_lvl && !up_rise) |=> (count_q <= TOP));

endmodule

// File: rtl/dsc_tc_gen.sv
module dsc_tc_gen
    import dsc_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic [CNT_W-1:0] count,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam logic [CNT_W-1:0] TOP = DECADE ? 4'd9 : 4'd15;

    always_comb begin
        carry_n  = ~((count == TOP) && !up_lvl);
        borrow_n = ~((count == '0)  && !dn_lvl);
    end

endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
    import dsc_pkg::*;
#(
    parameter bit DECADE      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb_up,
    input  logic       stb_dn,
    input  logic       load_n,
    input  logic       clear,
    input  logic [3:0] preset,
    output logic [3:0] count,
    output logic       carry_n,
    output logic       borrow_n
);

    localparam int              NSTB = 2;   // index 0: up, index 1: down
    localparam logic [CNT_W-1:0] TOP = DECADE ? 4'd9 : 4'd15;

    logic [NSTB-1:0] stb_raw;
    logic [NSTB-1:0] stb_lvl;
    logic [NSTB-1:0] stb_rise;

    assign stb_raw = {stb_dn, stb_up};

    for (genvar g = 0; g < NSTB; g++) begin : g_sync
        dsc_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (stb_raw[g]),
            .level  (stb_lvl[g]),
            .rise   (stb_rise[g])
        );
    end

    dsc_count_core #(.DECADE(DECADE)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .load_n  (load_n),
        .preset  (preset),
        .up_lvl  (stb_lvl[0]),
        .up_rise (stb_rise[0]),
        .dn_lvl  (stb_lvl[1]),
        .dn_rise (stb_rise[1]),
        .count   (count)
    );

    dsc_tc_gen #(.DECADE(DECADE)) u_tc (
        .count    (count),
        .up_lvl   (stb_lvl[0]),
        .dn_lvl   (stb_lvl[1]),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    a_r6_carry_only_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (count == TOP));

    a_r7_borrow_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> (count == '0));

endmodule

// File: tb/dual_strobe_counter_tb.sv
`timescale 1ns/1ps
module dual_strobe_counter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb_up = 1'b1, stb_dn = 1'b1, load_n = 1'b1, clear = 1'b0;
    logic [3:0] preset = '0;
    logic [3:0] dec_cnt, bin_cnt, hi_cnt;
    logic       dec_cy, dec_bw, bin_cy, bin_bw, hi_cy, hi_bw;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [3:0] m_dec, m_bin, m_hi;

    always #10 clk = ~clk;   // 50 MHz

    dual_strobe_counter #(.DECADE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .stb_up(stb_up), .stb_dn(stb_dn),
        .load_n(load_n), .clear(clear), .preset(preset),
        .count(dec_cnt), .carry_n(dec_cy), .borrow_n(dec_bw));

    dual_strobe_counter #(.DECADE(1'b0)) u_bin (
        .clk(clk), .rst_n(rst_n), .stb_up(stb_up), .stb_dn(stb_dn),
        .load_n(load_n), .clear(clear), .preset(preset),
        .count(bin_cnt), .carry_n(bin_cy), .borrow_n(bin_bw));

    // Upper cascade stage fed only by the decade stage's terminal counts
    dual_strobe_counter #(.DECADE(1'b1)) u_hi (
        .clk(clk), .rst_n(rst_n), .stb_up(dec_cy), .stb_dn(dec_bw),
        .load_n(1'b1), .clear(clear), .preset(4'd0),
        .count(hi_cnt), .carry_n(hi_cy), .borrow_n(hi_bw));

    function automatic logic [3:0] exp_up(input logic [3:0] v, input bit dec);
        if (!dec) return v + 4'd1;
        case (v)
            4'd9, 4'd11, 4'd13, 4'd15: return 4'd0;
            4'd10: return 4'd1;
            4'd12: return 4'd3;
            4'd14: return 4'd5;
            default: return v + 4'd1;
        endcase
    endfunction

    function automatic logic [3:0] exp_dn(input logic [3:0] v, input bit dec);
        if (!dec) return v - 4'd1;
        case (v)
            4'd0:  return 4'd9;
            4'd10: return 4'd4;
            4'd11: return 4'd5;
            4'd12: return 4'd6;
            4'd13: return 4'd7;
            4'd14: return 4'd8;
            4'd15: return 4'd9;
            default: return v - 4'd1;
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic chk_counts(input string tag);
        chk({tag, " decade"}, dec_cnt, m_dec);
        chk({tag, " binary"}, bin_cnt, m_bin);
        chk("R10 cascade upper stage", hi_cnt, m_hi);
    endtask

    task automatic pulse_up;
        stb_up = 1'b0;
        tick(4);
        chk("R6 decade carry", {3'b0, dec_cy}, {3'b0, !(m_dec == 4'd9)});
        chk("R6 binary carry", {3'b0, bin_cy}, {3'b0, !(m_bin == 4'd15)});
        stb_up = 1'b1;
        tick(6);
        if (m_dec == 4'd9) m_hi = exp_up(m_hi, 1'b1);
        m_dec = exp_up(m_dec, 1'b1);
        m_bin = exp_up(m_bin, 1'b0);
        chk("R6 carry released", {3'b0, dec_cy}, 4'd1);
        chk_counts("R1/R5/R9 up step");
    endtask

    task automatic pulse_dn;
        stb_dn = 1'b0;
        tick(4);
        chk("R7 decade borrow", {3'b0, dec_bw}, {3'b0, !(m_dec == 4'd0)});
        chk("R7 binary borrow", {3'b0, bin_bw}, {3'b0, !(m_bin == 4'd0)});
        stb_dn = 1'b1;
        tick(6);
        if (m_dec == 4'd0) m_hi = exp_dn(m_hi, 1'b1);
        m_dec = exp_dn(m_dec, 1'b1);
        m_bin = exp_dn(m_bin, 1'b0);
        chk("R7 borrow released", {3'b0, dec_bw}, 4'd1);
        chk_counts("R2/R5/R9 down step");
    endtask

    task automatic do_load(input logic [3:0] v);
        preset = v;
        load_n = 1'b0;
        tick(2);
        load_n = 1'b1;
        tick(1);
        m_dec = v;
        m_bin = v;
        chk_counts("R3 load");
    endtask

    task automatic do_clear;
        clear = 1'b1;
        tick(2);
        clear = 1'b0;
        tick(1);
        m_dec = '0; m_bin = '0; m_hi = '0;
        chk_counts("R4 clear");
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5EED_1234);
        m_dec = '0; m_bin = '0; m_hi = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R4 reset state
        chk_counts("R4 reset");
        chk("R4 reset carry", {3'b0, dec_cy}, 4'd1);
        chk("R4 reset borrow", {3'b0, dec_bw}, 4'd1);

        // R11 latency: change at a negedge, visible after the third posedge
        stb_up = 1'b0;
        tick(4);
        stb_up = 1'b1;
        tick(2);
        chk("R11 no early step", dec_cnt, 4'd0);
        tick(1);
        chk("R11 step at third edge", dec_cnt, 4'd1);
        tick(3);
        m_dec = 4'd1; m_bin = 4'd1;

        // R3 load overrides a strobe edge arriving during load
        stb_up = 1'b0;
        tick(4);
        preset = 4'd7; load_n = 1'b0; stb_up = 1'b1;
        tick(5);
        load_n = 1'b1;
        tick(3);
        m_dec = 4'd7; m_bin = 4'd7;
        chk_counts("R3 load beats strobe");

        // R4 clear beats load
        clear = 1'b1; load_n = 1'b0; preset = 4'd5;
        tick(2);
        m_dec = '0; m_bin = '0; m_hi = '0;
        chk_counts("R4 clear beats load");
        clear = 1'b0; load_n = 1'b1;
        tick(1);

        // R5 wraps and R10 cascade
        do_load(4'd9);
        pulse_up();
        do_clear();
        pulse_dn();
        do_load(4'd15);
        pulse_up();

        // R9 illegal decade states
        for (int v = 10; v < 16; v++) begin
            do_load(4'(v));
            pulse_up();
            do_load(4'(v));
            pulse_dn();
        end

        // R8 simultaneous edges
        do_load(4'd4);
        stb_up = 1'b0; stb_dn = 1'b0;
        tick(4);
        stb_up = 1'b1; stb_dn = 1'b1;
        tick(6);
        chk_counts("R8 both edges hold");

        // R1 gated up edge, then release of down counts down
        do_load(4'd5);
        stb_dn = 1'b0;
        tick(4);
        stb_up = 1'b0;
        tick(4);
        stb_up = 1'b1;
        tick(6);
        chk_counts("R1 up blocked by low down strobe");
        stb_dn = 1'b1;
        tick(6);
        m_dec = 4'd4; m_bin = 4'd4;
        chk_counts("R2 released down strobe counts");

        // R2 gated down edge, then release of up counts up
        do_load(4'd6);
        stb_up = 1'b0;
        tick(4);
        stb_dn = 1'b0;
        tick(4);
        stb_dn = 1'b1;
        tick(6);
        chk_counts("R2 down blocked by low up strobe");
        stb_up = 1'b1;
        tick(6);
        m_dec = 4'd7; m_bin = 4'd7;
        chk_counts("R1 released up strobe counts");

        // Constrained random mix
        do_clear();
        for (int i = 0; i < 300; i++) begin
            int op;
            op = int'($urandom % 8);
            if (op < 3)      pulse_up();
            else if (op < 6) pulse_dn();
            else if (op == 6) do_load(4'($urandom % 16));
            else             do_clear();
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule